// File: doc/BRIEF.md
# Parallel 8080-Style Panel Write Sequencer

This block turns a stream of words from an upstream pixel or command source into write cycles on an 8080-style parallel panel bus. Each accepted word becomes one write beat, which runs through four phases. First chip select is asserted and held for a setup time. Then the write strobe waits out its own setup time. Next the strobe is driven low for the active time. Finally the strobe is released and the bus is held before the beat ends. The register-select pin tells the panel whether the word is a command or data.

All four phase lengths and the interface enable come from one packed configuration word. The block reads that word only when a beat is accepted, so software may rewrite it at any time. A second word, which controls automatic frame-rate pacing, is accepted on a port and deliberately ignored. When the source has another word ready at the end of a beat, the next beat is chained: chip select stays low and the chip-select setup phase is skipped.

Top module: `i80_wr_seq`

## Requirements
- R1: After reset the sequencer is idle, with `lcd_cs_n` and `lcd_wr_n` both high.
- R2: Configuration word layout:
    - Bit 0 is the interface enable. While it is 0, `in_ready` stays low and no beat starts.
    - Bits 19:16 give the chip-select setup length, bits 15:12 the write setup length, bits 11:8 the write active length, and bits 7:4 the hold length, each counted in clock cycles.
- R3: `lcd_cs_n` goes low on the clock edge that accepts a word. For an unchained beat it stays low for csSetup + wrSetup + active + hold cycles.
- R4: `lcd_wr_n` is low only inside a beat. It is low for exactly the active length of cycles, which follow the setup cycles.
- R5: A phase length of 0 takes no cycle, except the active phase, which lasts at least one cycle when its field is 0.
- R6: `lcd_db` and `lcd_rs` take the accepted word on the accepting edge. They stay unchanged until the beat ends. `lcd_rs` is 0 for a command (`in_is_cmd`=1) and 1 for data.
- R7: `in_ready` is high only when the interface is enabled and either no beat is in progress or the current cycle is the final cycle of a beat.
- R8: A word accepted in the final cycle of a beat chains:
    - `lcd_cs_n` stays low and the chip-select setup phase is skipped.
    - If that final cycle had the strobe low and the write setup length is 0, one strobe-high cycle is inserted before the next active phase.
- R9: The timing fields are captured when a word is accepted. A rewrite during a beat takes effect from the next beat.
- R10: The frame-rate control word `afr_word` has no effect on any output.
- R11: Clearing the enable during a beat lets that beat finish, then no further beat starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Timing fields and interface enable |
| afr_word | input | 32 | Frame-rate pacing control, ignored |
| in_valid | input | 1 | Source has a word |
| in_ready | output | 1 | Sequencer takes the word on this edge |
| in_data | input | DATA_W | Word to write |
| in_is_cmd | input | 1 | 1 = command, 0 = data |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rs | output | 1 | Register select, 0 = command |
| lcd_db | output | DATA_W | Panel data bus |

## Verification
The bench builds the block with its default 16-bit data width and the fixed 4-bit timing fields. A reference model predicts the level of every pin in every cycle from a queue of pin states.

Directed segments use distinct field values so that a swapped field shows as a wrong phase length. Other directed segments cover zero-length phases, the clamped active phase and chained bursts with and without hold. They also cover mid-beat rewrites of the configuration and of the enable, and a nonzero frame-rate word. A long pseudo-random segment varies the fields between 0 and 3 and toggles the source's valid signal. This reaches every ordering of zero and nonzero phases at chain boundaries.

// File: rtl/i80_wr_pkg.sv
package i80_wr_pkg;

    localparam int TF_W        = 4;
    localparam int CFG_W       = 32;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_HLD_LSB = 4;
    localparam int N_FIELDS    = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSS,
        PH_WRS,
        PH_ACT,
        PH_HLD
    } phase_e;

    typedef struct packed {
        logic [TF_W-1:0] css;
        logic [TF_W-1:0] wrs;
        logic [TF_W-1:0] act;
        logic [TF_W-1:0] hld;
    } timing_t;

endpackage

// File: rtl/i80_cfg_decode.sv
module i80_cfg_decode
    import i80_wr_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output timing_t          tim,
    output logic             en
);

    logic [TF_W-1:0] fld [N_FIELDS];

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
        assign fld[i] = cfg_word[CFG_HLD_LSB + i*TF_W +: TF_W];
    end

    always_comb begin
        tim.hld = fld[0];
        tim.act = (fld[1] == '0) ? TF_W'(1) : fld[1];
        tim.wrs = fld[2];
        tim.css = fld[3];
        en      = cfg_word[CFG_EN_BIT];
    end

    always_comb begin
        assert (tim.act != '0) else $error("AST_ACT_CLAMP failed"); // R5
    end

endmodule

// File: rtl/i80_phase_plan.sv
module i80_phase_plan
    import i80_wr_pkg::*;
(
    input  logic            start_new,
    input  logic            chained,
    input  phase_e          cur_ph,
    input  timing_t         tim,
    output phase_e          nxt_ph,
    output logic [TF_W-1:0] nxt_cnt
);

    always_comb begin
        nxt_ph  = PH_IDLE;
        nxt_cnt = '0;
        if (start_new) begin
            if (!chained && tim.css != '0) begin
                nxt_ph  = PH_CSS;
                nxt_cnt = tim.css - TF_W'(1);
            end else if (tim.wrs != '0) begin
                nxt_ph  = PH_WRS;
                nxt_cnt = tim.wrs - TF_W'(1);
            end else if (chained && cur_ph == PH_ACT) begin
                nxt_ph  = PH_WRS;
                nxt_cnt = '0;
            end else begin
                nxt_ph  = PH_ACT;
                nxt_cnt = tim.act - TF_W'(1);
            end
        end else begin
            unique case (cur_ph)
                PH_CSS: begin
                    if (tim.wrs != '0) begin
                        nxt_ph  = PH_WRS;
                        nxt_cnt = tim.wrs - TF_W'(1);
                    end else begin
                        nxt_ph  = PH_ACT;
                        nxt_cnt = tim.act - TF_W'(1);
                    end
                end
                PH_WRS: begin
                    nxt_ph  = PH_ACT;
                    nxt_cnt = tim.act - TF_W'(1);
                end
                PH_ACT: begin
                    if (tim.hld != '0) begin
                        nxt_ph  = PH_HLD;
                        nxt_cnt = tim.hld - TF_W'(1);
                    end
                end
                default: begin
                    nxt_ph  = PH_IDLE;
                    nxt_cnt = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i80_wr_seq.sv
module i80_wr_seq
    import i80_wr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic [31:0]       afr_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_cmd,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rs,
    output logic [DATA_W-1:0] lcd_db
);

    typedef struct packed {
        phase_e            ph;
        logic [TF_W-1:0]   cnt;
        timing_t           tim;
        logic [DATA_W-1:0] dat;
        logic              rs;
    } seq_t;

    seq_t s_d, s_q;

    timing_t         live_tim;
    logic            live_en;
    timing_t         plan_tim;
    phase_e          plan_ph;
    logic [TF_W-1:0] plan_cnt;
    logic            phase_last;
    logic            beat_end;
    logic            acc;
    logic            unused_bits;

    assign unused_bits = ^{afr_word, cfg_word[31:20], cfg_word[3:1]};

    i80_cfg_decode u_dec (
        .cfg_word (cfg_word),
        .tim      (live_tim),
        .en       (live_en)
    );

    assign phase_last = (s_q.cnt == '0);
    assign beat_end   = phase_last &&
                        ((s_q.ph == PH_HLD) ||
                         (s_q.ph == PH_ACT && s_q.tim.hld == '0));
    assign in_ready   = live_en && (s_q.ph == PH_IDLE || beat_end);
    assign acc        = in_valid && in_ready;
    assign plan_tim   = acc ? live_tim : s_q.tim;

    i80_phase_plan u_plan (
        .start_new (acc),
        .chained   (s_q.ph != PH_IDLE),
        .cur_ph    (s_q.ph),
        .tim       (plan_tim),
        .nxt_ph    (plan_ph),
        .nxt_cnt   (plan_cnt)
    );

    always_comb begin
        s_d = s_q;
        if (acc) begin
            s_d.ph  = plan_ph;
            s_d.cnt = plan_cnt;
            s_d.tim = live_tim;
            s_d.dat = in_data;
            s_d.rs  = !in_is_cmd;
        end else if (s_q.ph != PH_IDLE) begin
            if (phase_last) begin
                s_d.ph  = plan_ph;
                s_d.cnt = plan_cnt;
            end else begin
                s_d.cnt = s_q.cnt - TF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.cnt <= '0;
            s_q.tim <= '0;
            s_q.dat <= '0;
            s_q.rs  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lcd_cs_n = (s_q.ph == PH_IDLE);
    assign lcd_wr_n = (s_q.ph != PH_ACT);
    assign lcd_rs   = s_q.rs;
    assign lcd_db   = s_q.dat;

    AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> !lcd_cs_n); // R4
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> cfg_word[0]); // R2
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n && !cfg_word[0] |=> lcd_cs_n); // R2
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_cs_n && !$past(lcd_cs_n) && !$past(in_valid && in_ready)
        |-> $stable(lcd_db) && $stable(lcd_rs)); // R6
    AST_CHAIN_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !lcd_cs_n |=> !lcd_cs_n); // R8
    AST_CS_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !lcd_cs_n); // R3

endmodule

// File: tb/test_i80_wr_seq.sv
module test_i80_wr_seq;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_word = 32'h0;
    logic [31:0]   afr_word = 32'h0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_is_cmd = 1'b0;
    logic          lcd_cs_n, lcd_wr_n, lcd_rs;
    logic [DW-1:0] lcd_db;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [1:0]    q[$];
    logic [DW-1:0] exp_db = '0;
    logic          exp_rs = 1'b0;
    logic [31:0]   lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    i80_wr_seq #(.DATA_W(DW)) i_i80_wr_seq (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .afr_word(afr_word),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_is_cmd(in_is_cmd), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
        .lcd_rs(lcd_rs), .lcd_db(lcd_db)
    );

    function automatic logic [31:0] mk(int css, int ws, int act, int hld, bit en);
        return (32'(css) << 16) | (32'(ws) << 12) | (32'(act) << 8) |
               (32'(hld) << 4) | 32'(en);
    endfunction

    task automatic chk(string req, string tag, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s (%s) cycle %0d: actual=%0h expected=%0h",
                     req, tag, cyc, act_v, exp_v);
        end
    endtask

    task automatic step(bit v, logic [DW-1:0] d, bit c, string tag);
        bit exp_rdy, accept, chained, prev_low;
        int css, ws, act, hld, n;
        in_valid  = v;
        in_data   = d;
        in_is_cmd = c;
        #1;
        exp_rdy = cfg_word[0] && (q.size() <= 1);
        chk("R3", tag, int'(lcd_cs_n), (q.size() == 0) ? 1 : int'(q[0][1]));
        chk("R4", tag, int'(lcd_wr_n), (q.size() == 0) ? 1 : int'(q[0][0]));
        chk("R7", tag, int'(in_ready), int'(exp_rdy));
        if (q.size() > 0) begin
            chk("R6", tag, int'(lcd_db), int'(exp_db));
            chk("R6", tag, int'(lcd_rs), int'(exp_rs));
        end
        accept   = v && exp_rdy;
        chained  = (q.size() == 1);
        prev_low = (q.size() > 0) && (q[0][0] == 1'b0);
        if (q.size() > 0) void'(q.pop_front());
        if (accept) begin
            css = int'(cfg_word[19:16]);
            ws  = int'(cfg_word[15:12]);
            act = int'(cfg_word[11:8]);
            hld = int'(cfg_word[7:4]);
            if (act == 0) act = 1;
            if (!chained) for (int i = 0; i < css; i++) q.push_back(2'b01);
            n = ws;
            if (chained && prev_low && n == 0) n = 1;
            for (int i = 0; i < n; i++) q.push_back(2'b01);
            for (int i = 0; i < act; i++) q.push_back(2'b00);
            for (int i = 0; i < hld; i++) q.push_back(2'b01);
            exp_db = d;
            exp_rs = !c;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(int k, string tag);
        for (int i = 0; i < k; i++) step(1'b0, '0, 1'b0, tag);
    endtask

    task automatic burst(int k, logic [DW-1:0] base, string tag);
        for (int i = 0; i < k; i++) begin
            step(1'b1, base + DW'(i), i[0], tag);
            while (q.size() > 1) step(1'b1, base + DW'(i + 1), i[0] ^ 1'b1, tag);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: cycles=150000 expected fewer");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        #1;
        chk("R1", "reset", int'(lcd_cs_n), 1);
        chk("R1", "reset", int'(lcd_wr_n), 1);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // default timing: only a one-cycle active phase
        cfg_word = mk(0, 0, 1, 0, 1);
        step(1'b1, 16'hA5A5, 1'b1, "R6");
        idle(3, "R6");

        // distinct field values expose field placement
        cfg_word = mk(1, 2, 3, 4, 1);
        step(1'b1, 16'h1234, 1'b0, "R2");
        idle(12, "R2");

        // enable clear: valid held, nothing starts
        cfg_word = mk(1, 1, 1, 1, 0);
        idle(1, "R2");
        for (int i = 0; i < 6; i++) step(1'b1, 16'hDEAD, 1'b0, "R2");

        // clamp of active field 0
        cfg_word = mk(0, 0, 0, 0, 1);
        step(1'b1, 16'h0F0F, 1'b0, "R5");
        idle(3, "R5");

        // chained bursts with hold, and with no hold/no setup (gap)
        cfg_word = mk(2, 1, 3, 2, 1);
        burst(4, 16'h1000, "R8");
        idle(4, "R8");
        cfg_word = mk(1, 0, 2, 0, 1);
        burst(5, 16'h2000, "R8");
        idle(4, "R8");

        // rewrite mid-beat applies next beat
        cfg_word = mk(1, 1, 4, 1, 1);
        step(1'b1, 16'h3333, 1'b0, "R9");
        step(1'b0, '0, 1'b0, "R9");
        cfg_word = mk(0, 2, 1, 3, 1);
        idle(4, "R9");
        burst(2, 16'h3400, "R9");
        idle(6, "R9");

        // enable cleared mid-beat
        cfg_word = mk(1, 1, 3, 2, 1);
        step(1'b1, 16'h4444, 1'b1, "R11");
        cfg_word = mk(1, 1, 3, 2, 0);
        for (int i = 0; i < 10; i++) step(1'b1, 16'h4545, 1'b0, "R11");

        // frame-rate word ignored
        afr_word = 32'hFFFF_FFFF;
        cfg_word = mk(1, 1, 2, 1, 1);
        burst(3, 16'h5000, "R10");
        idle(6, "R10");
        afr_word = 32'h0;

        // pseudo-random mix
        for (int blk = 0; blk < 80; blk++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cfg_word = mk(int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[5:4]),
                          int'(lfsr[7:6]), (lfsr[12:10] != 3'b000));
            for (int i = 0; i < 40; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                step(lfsr[0] | lfsr[1], lfsr[23:8], lfsr[2], "R3");
            end
        end
        cfg_word = mk(0, 0, 1, 0, 1);
        idle(20, "R4");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule